// File: doc/BRIEF.md
# Global Set/Reset Controller

This block produces the chip-wide set/reset and delivers it as per-cell set and reset strobes to groups of storage elements. From power-on until the configuration logic reports completion, the global signal is held active for every cell. Once completion is seen, an internal step counter counts a programmable number of start-up clocks. At that step the global signal is released and the chosen post-configuration source takes over. The source can be nothing (the default), the synchronized reset pad, or an internal corner routing signal. The sense of the source is active-low unless the invert bit is set.

The reset pad has two roles. While configuration is running, pulling it low raises a configuration-abort request. After configuration it can serve as the global reset source. Each cell has a mode bit that chooses whether the global signal sets or clears its storage. Each cell also has an enable bit, and once configuration is over a cell with that bit clear ignores the global signal. All pins are plain control levels. There is no data stream, so no valid/ready handshake and no back-pressure.

Top module: `gsr_ctrl`

## Requirements
- R1: After the start-up release, the selected source is active when its level is 0 while `pol_inv`=0, and active when its level is 1 while `pol_inv`=1.
- R2: From `por_n` low until release, the global signal is active for every cell whatever the enable bits, source select or pad. Each cell then shows `cell_set_o[i]`=`cell_set_mode[i]` and `cell_rst_o[i]`=!`cell_set_mode[i]`.
- R3: The global signal stays active on the first `rel_step`+1 rising edges, counting from the edge that samples `cfg_done`=1. It is released from edge `rel_step`+2 on.
- R4: After release, `src_sel` encodes the source: 0 none, 1 synchronized pad, 2 `corner_sig`, 3 none. With no source the global signal is inactive.
- R5: `cfg_abort` is 1 only before release, while `cfg_active`=1 and the synchronized pad is 0. It returns to 0 once the start-up count begins.
- R6: While the global signal is active, a cell with mode bit 1 receives a set strobe and a cell with mode bit 0 receives a reset strobe. No cell ever receives both.
- R7: After release, a cell whose `cell_gsr_en` bit is 0 receives neither strobe, even while the global signal is active.
- R8: The pad passes through a two-flip-flop synchronizer, reset to 1. A pad change becomes visible on `cfg_abort` and as a reset source after the second rising edge, and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Start-up and synchronizer clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| cfg_active | input | 1 | Configuration in progress |
| cfg_done | input | 1 | Configuration complete, sampled before release |
| rst_pad_n | input | 1 | Raw reset pad, asynchronous, active low |
| corner_sig | input | 1 | Internal routing signal usable as reset source |
| src_sel | input | 2 | Post-configuration source select |
| pol_inv | input | 1 | Invert the sense of the selected source |
| rel_step | input | STEP_W | Start-up step at which release happens |
| cell_gsr_en | input | NCELL | Per-cell global signal enable after configuration |
| cell_set_mode | input | NCELL | Per-cell mode: 1 set, 0 reset |
| cell_set_o | output | NCELL | Per-cell set strobe |
| cell_rst_o | output | NCELL | Per-cell reset strobe |
| cfg_abort | output | 1 | Configuration-abort request |

## Verification
The abort request and the start of the start-up count can fall in the same cycle. To provoke this, the bench drops the pad during configuration, waits until the synchronized low shows on `cfg_abort`, and raises `cfg_done` in that same cycle. It then checks that the abort is seen while the count begins, that it clears on the next edge, and that the global signal stays active until the programmed step. After release, the pad selected as source is found still low, so the global signal must stay active without a gap until the pad returns high and clears the synchronizer.

// File: rtl/gsr_pkg.sv
`timescale 1ns/1ps
package gsr_pkg;
  typedef enum logic [1:0] {
    PH_CFG   = 2'd0,
    PH_START = 2'd1,
    PH_USER  = 2'd2
  } gsr_phase_e;

  typedef enum logic [1:0] {
    SRC_OFF    = 2'd0,
    SRC_PAD    = 2'd1,
    SRC_CORNER = 2'd2,
    SRC_RSVD   = 2'd3
  } gsr_src_e;
endpackage

// File: rtl/gsr_sync.sv
`timescale 1ns/1ps
module gsr_sync #(
  parameter int    STAGES  = 2,
  parameter logic  RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic por_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];

  AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (!por_n)
    chain[STAGES-1] == $past(chain[STAGES-2])); // R8
endmodule

// File: rtl/gsr_seq.sv
`timescale 1ns/1ps
module gsr_seq
  import gsr_pkg::*;
#(
  parameter int STEP_W = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              cfg_done,
  input  logic [STEP_W-1:0] rel_step,
  output gsr_phase_e        phase,
  output logic              in_user
);
  logic [STEP_W-1:0] step_cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      phase    <= PH_CFG;
      step_cnt <= '0;
    end else begin
      unique case (phase)
        PH_CFG: begin
          step_cnt <= '0;
          if (cfg_done) phase <= PH_START;
        end
        PH_START: begin
          if (step_cnt == rel_step) phase <= PH_USER;
          else                      step_cnt <= step_cnt + 1'b1;
        end
        default: phase <= PH_USER;
      endcase
    end
  end

  assign in_user = (phase == PH_USER);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!por_n)
    (phase == PH_START) |-> (step_cnt <= rel_step)); // R3
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    (phase == PH_CFG && !cfg_done) |=> (phase == PH_CFG)); // R2
  AST_USER_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    (phase == PH_USER) |=> (phase == PH_USER)); // R3
endmodule

// File: rtl/gsr_src.sv
`timescale 1ns/1ps
module gsr_src
  import gsr_pkg::*;
(
  input  logic [1:0] src_sel,
  input  logic       pol_inv,
  input  logic       pad_lvl,
  input  logic       corner_sig,
  output logic       user_act
);
  logic lvl;
  logic has_src;

  always_comb begin
    unique case (gsr_src_e'(src_sel))
      SRC_PAD:    begin lvl = pad_lvl;    has_src = 1'b1; end
      SRC_CORNER: begin lvl = corner_sig; has_src = 1'b1; end
      default:    begin lvl = 1'b1;       has_src = 1'b0; end
    endcase
    user_act = has_src & (pol_inv ? lvl : ~lvl);
  end
endmodule

// File: rtl/gsr_cell.sv
`timescale 1ns/1ps
module gsr_cell (
  input  logic clk,
  input  logic por_n,
  input  logic gsr_act,
  input  logic in_user,
  input  logic en,
  input  logic set_mode,
  output logic set_o,
  output logic rst_o
);
  logic hit;

  assign hit   = gsr_act & (~in_user | en);
  assign set_o = hit &  set_mode;
  assign rst_o = hit & ~set_mode;

  AST_SET_RST_EXCL: assert property (@(posedge clk) disable iff (!por_n)
    !(set_o && rst_o)); // R6
  AST_CFG_REACH: assert property (@(posedge clk) disable iff (!por_n)
    (!in_user && gsr_act) |-> (set_o || rst_o)); // R2
endmodule

// File: rtl/gsr_ctrl.sv
`timescale 1ns/1ps
module gsr_ctrl
  import gsr_pkg::*;
#(
  parameter int NCELL  = 4,
  parameter int STEP_W = 2,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              cfg_active,
  input  logic              cfg_done,
  input  logic              rst_pad_n,
  input  logic              corner_sig,
  input  logic [1:0]        src_sel,
  input  logic              pol_inv,
  input  logic [STEP_W-1:0] rel_step,
  input  logic [NCELL-1:0]  cell_gsr_en,
  input  logic [NCELL-1:0]  cell_set_mode,
  output logic [NCELL-1:0]  cell_set_o,
  output logic [NCELL-1:0]  cell_rst_o,
  output logic              cfg_abort
);
  gsr_phase_e phase;
  logic       in_user;
  logic       pad_q;
  logic       user_act;
  logic       gsr_act;

  gsr_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_pad_sync (
    .clk(clk), .por_n(por_n), .d_async(rst_pad_n), .q_sync(pad_q)
  );

  gsr_seq #(.STEP_W(STEP_W)) u_seq (
    .clk(clk), .por_n(por_n), .cfg_done(cfg_done), .rel_step(rel_step),
    .phase(phase), .in_user(in_user)
  );

  gsr_src u_src (
    .src_sel(src_sel), .pol_inv(pol_inv), .pad_lvl(pad_q),
    .corner_sig(corner_sig), .user_act(user_act)
  );

  assign gsr_act   = ~in_user | user_act;
  assign cfg_abort = (phase == PH_CFG) & cfg_active & ~pad_q;

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    gsr_cell u_cell (
      .clk(clk), .por_n(por_n), .gsr_act(gsr_act), .in_user(in_user),
      .en(cell_gsr_en[i]), .set_mode(cell_set_mode[i]),
      .set_o(cell_set_o[i]), .rst_o(cell_rst_o[i])
    );
  end

  AST_PRE_USER_ACTIVE: assert property (@(posedge clk) disable iff (!por_n)
    !in_user |-> ((cell_set_o | cell_rst_o) == {NCELL{1'b1}})); // R2
  AST_ABORT_CFG_ONLY: assert property (@(posedge clk) disable iff (!por_n)
    cfg_abort |-> (phase == PH_CFG && cfg_active)); // R5
  AST_NO_ABORT_USER: assert property (@(posedge clk) disable iff (!por_n)
    in_user |-> !cfg_abort); // R5
endmodule

// File: tb/tb_gsr_ctrl.sv
`timescale 1ns/1ps
module tb_gsr_ctrl;
  localparam int N = 4;
  localparam int SW = 2;

  logic clk = 1'b0;
  logic por_n = 1'b0, cfg_active = 1'b0, cfg_done = 1'b0;
  logic rst_pad_n = 1'b1, corner_sig = 1'b0, pol_inv = 1'b0;
  logic [1:0] src_sel = 2'd0;
  logic [SW-1:0] rel_step = '0;
  logic [N-1:0] cell_gsr_en = '0, cell_set_mode = '0;
  logic [N-1:0] cell_set_o, cell_rst_o;
  logic cfg_abort;
  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  gsr_ctrl #(.NCELL(N), .STEP_W(SW), .SYNC_N(2)) dut (
    .clk(clk), .por_n(por_n), .cfg_active(cfg_active), .cfg_done(cfg_done),
    .rst_pad_n(rst_pad_n), .corner_sig(corner_sig), .src_sel(src_sel),
    .pol_inv(pol_inv), .rel_step(rel_step), .cell_gsr_en(cell_gsr_en),
    .cell_set_mode(cell_set_mode), .cell_set_o(cell_set_o),
    .cell_rst_o(cell_rst_o), .cfg_abort(cfg_abort)
  );

  task automatic chk(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // all cells hit by an active global signal (R2 / R6)
  task automatic chk_all_active(input string tag);
    chk(cell_set_o, cell_set_mode, {tag, " set"});
    chk(cell_rst_o, ~cell_set_mode, {tag, " rst"});
  endtask

  task automatic chk_released(input string tag);
    chk(cell_set_o | cell_rst_o, '0, tag);
  endtask

  task automatic start_cfg();
    @(negedge clk);
    por_n = 1'b0; cfg_done = 1'b0; cfg_active = 1'b0; rst_pad_n = 1'b1;
    src_sel = 2'd0; pol_inv = 1'b0;
    @(negedge clk);
    por_n = 1'b1; cfg_active = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic exp_act(input logic [1:0] s, input logic inv,
                                   input logic pad, input logic cor);
    logic lv;
    if (s == 2'd1)      lv = pad;
    else if (s == 2'd2) lv = cor;
    else                return 1'b0;
    return inv ? lv : ~lv;
  endfunction

  initial begin
    #200000;
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // reset state: R2
    cell_set_mode = 4'b1010; cell_gsr_en = 4'b0000;
    #7;
    chk_all_active("R2 por state");
    chk(N'(cfg_abort), '0, "R5 no abort in por");

    start_cfg();
    // R2/R6/R7: during configuration every cell hit, enables ignored
    for (int c = 0; c < 256; c++) begin
      @(negedge clk);
      cell_gsr_en = c[7:4]; cell_set_mode = c[3:0];
      src_sel = c[1:0]; pol_inv = c[5];
      #1;
      chk_all_active("R2 R6 R7 cfg sweep");
    end
    src_sel = 2'd0; pol_inv = 1'b0;

    // R5/R8: pad low during config, two-edge latency
    @(negedge clk); rst_pad_n = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(N'(cfg_abort), '0, "R8 abort not after one edge");
    @(posedge clk); @(negedge clk);
    chk(N'(cfg_abort), N'(1), "R5 R8 abort after two edges");
    cfg_active = 1'b0; #1;
    chk(N'(cfg_abort), '0, "R5 abort needs cfg_active");
    cfg_active = 1'b1;
    rst_pad_n = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(N'(cfg_abort), '0, "R5 abort clears with pad high");

    // R3: release step sweep
    for (int r = 0; r < 4; r++) begin
      start_cfg();
      cell_gsr_en = 4'b1111; cell_set_mode = 4'b0110; rel_step = SW'(r);
      cfg_active = 1'b0; cfg_done = 1'b1;
      for (int k = 0; k <= r + 1; k++) begin
        @(posedge clk); @(negedge clk);
        if (k <= r) chk_all_active($sformatf("R3 step %0d held k=%0d", r, k));
        else        chk_released($sformatf("R3 step %0d released", r));
      end
    end

    // coincidence: abort and start-up begin together, pad becomes source (R5, R4, R1)
    start_cfg();
    rel_step = 2'd1; cell_gsr_en = 4'b1111; cell_set_mode = 4'b0011;
    src_sel = 2'd1; pol_inv = 1'b0;
    rst_pad_n = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(N'(cfg_abort), N'(1), "R5 abort before done");
    cfg_done = 1'b1; cfg_active = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(N'(cfg_abort), '0, "R5 abort drops at start");
    chk_all_active("R3 held step0");
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); @(negedge clk);
      chk_all_active("R4 R1 pad source keeps active");
    end
    rst_pad_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk_all_active("R8 pad high not after one edge");
    @(posedge clk); @(negedge clk);
    chk_released("R4 R8 pad high releases");

    // user-phase exhaustive sweep: R1 R4 R6 R7
    for (int s = 0; s < 4; s++)
      for (int v = 0; v < 8; v++) begin
        @(negedge clk);
        src_sel = 2'(s); pol_inv = v[2]; rst_pad_n = v[1]; corner_sig = v[0];
        @(posedge clk); @(posedge clk);
        for (int c = 0; c < 256; c++) begin
          logic a;
          logic [N-1:0] en, md;
          @(negedge clk);
          en = c[7:4]; md = c[3:0];
          cell_gsr_en = en; cell_set_mode = md;
          #1;
          a = exp_act(2'(s), v[2], v[1], v[0]);
          chk(cell_set_o, {N{a}} & en & md, $sformatf("R1 R4 R6 R7 set s=%0d v=%0d", s, v));
          chk(cell_rst_o, {N{a}} & en & ~md, $sformatf("R1 R4 R6 R7 rst s=%0d v=%0d", s, v));
          chk(N'(cfg_abort), '0, "R5 no abort after release");
        end
      end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule